// File: doc/BRIEF.md
# Serial Command Front End for a Dual Digital Potentiometer

This block is the serial slave side of a two-channel digital potentiometer. A host selects it with an active-low chip select and sends bytes MSB first on SI. The clock idles low; SI is sampled on rising SCK and SO changes on falling SCK. The first byte names the device type and the strapped address. The second byte carries a four-bit opcode and the register and pot pointers. Some commands take a third byte: data for writes, or returned data on SO for reads. After the step opcode, the block emits a step on every further SCK pulse.

The wiper registers and the nonvolatile store sit outside the block. They see single-cycle strobes, the pot and register pointers, and an eight-bit data value. For reads they return a byte on `rd_data`, chosen from `rd_is_wcr`, `pot_sel` and `reg_sel`. All pins are synchronised into the system clock `clk`, and edges are detected there. Each SCK phase must therefore last at least six `clk` cycles. An active-low pause input (`hold_n`) can suspend a frame without losing its place.

Top module: `potcmd_frontend`

## Requirements
- R1: `so_oe` is 0 out of reset, and it is 0 within a few clock cycles of `cs_n` going high.
- R2: The first byte must equal 0101, then 00, then `dev_addr[1:0]`. If it does not, the frame issues no strobe and never enables SO.
- R3: Read wiper (opcode 1001) and read data register (opcode 1011) return `rd_data` on SO during byte three, MSB first. SO changes on falling SCK. Byte two holds the opcode in bits 7:4, the register number in bits 3:2, a zero in bit 1 and the pot in bit 0.
- R4: Read status (opcode 0101) returns seven zeros and then `wip`.
- R5: Write wiper (1010) and write data register (1100) each pulse their strobe once when CS rises after exactly 24 bits. The strobe carries byte three on `wr_data` and the byte-two pointers.
- R6: Transfer data register to wiper (1101) pulses `ld_wcr_stb`, and transfer wiper to data register (1110) pulses `st_dr_stb`. Either fires when CS rises after exactly 16 bits, with `all_pots` = 0.
- R7: The all-pot forms (0001 load, 1000 store) pulse the same strobes with `all_pots` = 1 and the register number.
- R8: After opcode 0010, each rising SCK from bit 17 onward pulses `step_stb`, with `step_up` equal to SI at that edge.
- R9: If CS rises before a command is complete, no strobe is issued.
- R10: An unlisted opcode, or byte two with bit 1 set, produces no strobe, and SO stays disabled.
- R11: Taking `hold_n` low while SCK is low disables SO and makes the block ignore SCK. Raising `hold_n` while SCK is low resumes the frame at the same bit.
- R12: After reset, no command is accepted until `cs_n` has been seen going from high to low.
- R13: At most one strobe is high in any cycle, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| dev_addr | input | 2 | Strapped device address |
| wip | input | 1 | Store busy flag, returned by the status read |
| rd_data | input | 8 | Byte returned by the external registers |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO |
| rd_is_wcr | output | 1 | Current read targets a wiper register |
| pot_sel | output | 1 | Pot pointer |
| reg_sel | output | 2 | Data register pointer |
| wr_data | output | 8 | Data byte for write strobes |
| wr_wcr_stb | output | 1 | Write wiper strobe |
| wr_dr_stb | output | 1 | Write data register strobe |
| ld_wcr_stb | output | 1 | Data register to wiper transfer strobe |
| st_dr_stb | output | 1 | Wiper to data register transfer strobe |
| all_pots | output | 1 | Transfer applies to both pots |
| step_stb | output | 1 | One wiper step |
| step_up | output | 1 | Step direction, 1 = toward the high end |

## Verification
The bench targets the edges of the framing rules.

**Truncated frames.** It cuts frames short at 20 and 12 bits. A design that counted only to the byte boundary would then fire a write with half a data byte.

**Invalid frames.** It sends bytes that differ from a valid frame in a single field: the device type, the address, the reserved zero bit, or the opcode. A loose compare would act on them or drive SO.

**Pause.** It pauses both inside a byte and during the read-back, and clocks junk SCK pulses while paused. A design that kept counting would shift the data byte or fire an extra step.

**Before the first select.** It clocks a full frame with CS already low from reset. A design that armed on the level rather than the fall would accept that frame.

// File: rtl/potcmd_pkg.sv
package potcmd_pkg;
  localparam int BYTE_W = 8;

  // Decoded command kinds (opcode values are fixed by the serial protocol)
  typedef enum logic [3:0] {
    K_NONE, K_RD_WCR, K_RD_DR, K_RD_STAT, K_WR_WCR, K_WR_DR,
    K_LD, K_ST, K_GLD, K_GST, K_STEP
  } kind_e;

  function automatic kind_e decode_op(input logic [3:0] op);
    case (op)
      4'b1001: return K_RD_WCR;
      4'b1010: return K_WR_WCR;
      4'b1011: return K_RD_DR;
      4'b1100: return K_WR_DR;
      4'b1101: return K_LD;
      4'b1110: return K_ST;
      4'b0001: return K_GLD;
      4'b1000: return K_GST;
      4'b0010: return K_STEP;
      4'b0101: return K_RD_STAT;
      default: return K_NONE;
    endcase
  endfunction

  function automatic logic id_match(input logic [BYTE_W-1:0] b, input logic [1:0] a);
    return b == {4'b0101, 2'b00, a};
  endfunction

  function automatic logic is_read(input kind_e k);
    return (k == K_RD_WCR) || (k == K_RD_DR) || (k == K_RD_STAT);
  endfunction

  function automatic logic has_data(input kind_e k);
    return (k == K_WR_WCR) || (k == K_WR_DR);
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic busy);
    return {{(BYTE_W-1){1'b0}}, busy};
  endfunction
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  // Reset to zero: a chip select already low at reset never looks like a fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/pcd_frame.sv
module pcd_frame
  import potcmd_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_cs,
  input  logic              s_sck,
  input  logic              s_si,
  input  logic              s_hold,
  output logic              cs_fall,
  output logic              cs_rise,
  output logic              rise_q,
  output logic              fall_q,
  output logic              hold_act,
  output logic              active,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [BYTE_W-1:0] nxt_byte
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(3 * BYTE_W);

  logic cs_d, sck_d;
  logic [BYTE_W-2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d  <= 1'b0;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= s_cs;
      sck_d <= s_sck;
    end
  end

  assign cs_fall = cs_d & ~s_cs;
  assign cs_rise = ~cs_d & s_cs;
  // Qualified serial edges: only inside a frame and outside a pause
  assign rise_q  = active & ~hold_act & ~s_cs & s_sck & ~sck_d;
  assign fall_q  = active & ~hold_act & ~s_cs & ~s_sck & sck_d;
  assign nxt_byte = {sh, s_si};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      hold_act <= 1'b0;
      bit_cnt  <= '0;
      sh       <= '0;
    end else begin
      if (cs_rise)      active <= 1'b0;
      else if (cs_fall) active <= 1'b1;
      // Pause state only changes while the serial clock is low
      if (!s_sck) hold_act <= ~s_hold;
      if (cs_fall)                           bit_cnt <= '0;
      else if (rise_q && bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      if (rise_q) sh <= nxt_byte[BYTE_W-2:0];
    end
  end

  // R11
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !cs_fall) |=> $stable(bit_cnt));
endmodule

// File: rtl/pcd_decode.sv
module pcd_decode
  import potcmd_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              rise_q,
  input  logic              s_si,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [BYTE_W-1:0] nxt_byte,
  input  logic [1:0]        dev_addr,
  output kind_e             kind_q,
  output logic              load_req,
  output logic              pot_sel,
  output logic [1:0]        reg_sel,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_wcr_stb,
  output logic              wr_dr_stb,
  output logic              ld_wcr_stb,
  output logic              st_dr_stb,
  output logic              all_pots,
  output logic              step_stb,
  output logic              step_up
);
  localparam logic [CNT_W-1:0] END_ID  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] END_INS = CNT_W'(2 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] END_DAT = CNT_W'(3 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] TWO_B   = CNT_W'(2 * BYTE_W);

  logic  id_ok, data_ok;
  kind_e kind_nxt;
  logic  two_done;

  // Bit 1 of the instruction byte is reserved zero; anything else is ignored
  assign kind_nxt = nxt_byte[1] ? K_NONE : decode_op(nxt_byte[7:4]);
  assign two_done = (bit_cnt == TWO_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_ok <= 1'b0; data_ok <= 1'b0; kind_q <= K_NONE; load_req <= 1'b0;
      pot_sel <= 1'b0; reg_sel <= '0; wr_data <= '0;
      wr_wcr_stb <= 1'b0; wr_dr_stb <= 1'b0; ld_wcr_stb <= 1'b0; st_dr_stb <= 1'b0;
      all_pots <= 1'b0; step_stb <= 1'b0; step_up <= 1'b0;
    end else begin
      wr_wcr_stb <= 1'b0; wr_dr_stb <= 1'b0; ld_wcr_stb <= 1'b0; st_dr_stb <= 1'b0;
      step_stb <= 1'b0; load_req <= 1'b0;
      if (cs_fall) begin
        id_ok <= 1'b0; data_ok <= 1'b0; kind_q <= K_NONE;
      end else if (cs_rise) begin
        case (kind_q)
          K_WR_WCR: wr_wcr_stb <= data_ok;
          K_WR_DR:  wr_dr_stb  <= data_ok;
          K_LD:  begin ld_wcr_stb <= two_done; all_pots <= 1'b0; end
          K_GLD: begin ld_wcr_stb <= two_done; all_pots <= 1'b1; end
          K_ST:  begin st_dr_stb  <= two_done; all_pots <= 1'b0; end
          K_GST: begin st_dr_stb  <= two_done; all_pots <= 1'b1; end
          default: ;
        endcase
        id_ok <= 1'b0; data_ok <= 1'b0; kind_q <= K_NONE;
      end else if (rise_q) begin
        if (bit_cnt == END_ID) id_ok <= id_match(nxt_byte, dev_addr);
        if (bit_cnt == END_INS && id_ok) begin
          kind_q   <= kind_nxt;
          pot_sel  <= nxt_byte[0];
          reg_sel  <= nxt_byte[3:2];
          load_req <= is_read(kind_nxt);
        end
        if (bit_cnt == END_DAT && has_data(kind_q)) begin
          wr_data <= nxt_byte;
          data_ok <= 1'b1;
        end
        if (kind_q == K_STEP && bit_cnt >= TWO_B) begin
          step_stb <= 1'b1;
          step_up  <= s_si;
        end
      end
    end
  end

  // R5
  wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wcr_stb || wr_dr_stb) |-> ($past(cs_rise) && $past(data_ok)));
  // R6
  xfr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_wcr_stb || st_dr_stb) |-> ($past(bit_cnt) == TWO_B));
  // R8
  step_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_stb |-> ($past(rise_q) && $past(kind_q == K_STEP)));
endmodule

// File: rtl/pcd_sodrv.sv
module pcd_sodrv
  import potcmd_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              s_cs,
  input  logic              active,
  input  logic              hold_act,
  input  logic              fall_q,
  input  logic              load_req,
  input  logic              wip,
  input  kind_e             kind_q,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              so,
  output logic              so_oe
);
  localparam logic [CNT_W-1:0] TWO_B   = CNT_W'(2 * BYTE_W);
  localparam logic [CNT_W-1:0] THREE_B = CNT_W'(3 * BYTE_W);

  logic              reading, so_en, so_q;
  logic [BYTE_W-1:0] out_sr;
  logic              shift_now;

  assign shift_now = fall_q && reading && bit_cnt >= TWO_B && bit_cnt < THREE_B;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reading <= 1'b0; so_en <= 1'b0; so_q <= 1'b0; out_sr <= '0;
    end else if (cs_fall || cs_rise) begin
      reading <= 1'b0; so_en <= 1'b0;
    end else begin
      if (load_req) begin
        reading <= 1'b1;
        out_sr  <= (kind_q == K_RD_STAT) ? status_byte(wip) : rd_data;
      end
      if (shift_now) begin
        so_q   <= out_sr[BYTE_W-1];
        out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
        so_en  <= 1'b1;
      end
    end
  end

  assign so_oe = so_en & active & ~hold_act;
  assign so    = so_q;

  // R1
  so_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cs && $past(s_cs)) |-> !so_oe);
endmodule

// File: rtl/potcmd_frontend.sv
module potcmd_frontend
  import potcmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  input  logic [1:0]        dev_addr,
  input  logic              wip,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              so,
  output logic              so_oe,
  output logic              rd_is_wcr,
  output logic              pot_sel,
  output logic [1:0]        reg_sel,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_wcr_stb,
  output logic              wr_dr_stb,
  output logic              ld_wcr_stb,
  output logic              st_dr_stb,
  output logic              all_pots,
  output logic              step_stb,
  output logic              step_up
);
  localparam int CNT_W = $clog2(3 * BYTE_W + 1);

  logic [3:0]        s_pins;
  logic              cs_fall, cs_rise, rise_q, fall_q, hold_act, active, load_req;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] nxt_byte;
  kind_e             kind_q;

  pcd_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({hold_n, si, sck, cs_n}), .dout(s_pins));

  pcd_frame #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .s_cs(s_pins[0]), .s_sck(s_pins[1]), .s_si(s_pins[2]),
    .s_hold(s_pins[3]), .cs_fall(cs_fall), .cs_rise(cs_rise), .rise_q(rise_q),
    .fall_q(fall_q), .hold_act(hold_act), .active(active), .bit_cnt(bit_cnt),
    .nxt_byte(nxt_byte));

  pcd_decode #(.CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise), .rise_q(rise_q),
    .s_si(s_pins[2]), .bit_cnt(bit_cnt), .nxt_byte(nxt_byte), .dev_addr(dev_addr),
    .kind_q(kind_q), .load_req(load_req), .pot_sel(pot_sel), .reg_sel(reg_sel),
    .wr_data(wr_data), .wr_wcr_stb(wr_wcr_stb), .wr_dr_stb(wr_dr_stb),
    .ld_wcr_stb(ld_wcr_stb), .st_dr_stb(st_dr_stb), .all_pots(all_pots),
    .step_stb(step_stb), .step_up(step_up));

  pcd_sodrv #(.CNT_W(CNT_W)) u_so (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise), .s_cs(s_pins[0]),
    .active(active), .hold_act(hold_act), .fall_q(fall_q), .load_req(load_req),
    .wip(wip), .kind_q(kind_q), .bit_cnt(bit_cnt), .rd_data(rd_data),
    .so(so), .so_oe(so_oe));

  assign rd_is_wcr = (kind_q == K_RD_WCR);

  // R13
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_wcr_stb, wr_dr_stb, ld_wcr_stb, st_dr_stb, step_stb}));
endmodule

// File: tb/sim_potcmd_frontend.sv
module sim_potcmd_frontend;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wip = 1'b0;
  logic [1:0] dev_addr = 2'b10;
  logic [7:0] rd_data, wr_data;
  logic so, so_oe, rd_is_wcr, pot_sel, all_pots, step_up;
  logic [1:0] reg_sel;
  logic wr_wcr_stb, wr_dr_stb, ld_wcr_stb, st_dr_stb, step_stb;

  always #10 clk = ~clk;

  potcmd_frontend u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .dev_addr(dev_addr), .wip(wip), .rd_data(rd_data), .so(so), .so_oe(so_oe),
    .rd_is_wcr(rd_is_wcr), .pot_sel(pot_sel), .reg_sel(reg_sel), .wr_data(wr_data),
    .wr_wcr_stb(wr_wcr_stb), .wr_dr_stb(wr_dr_stb), .ld_wcr_stb(ld_wcr_stb),
    .st_dr_stb(st_dr_stb), .all_pots(all_pots), .step_stb(step_stb), .step_up(step_up));

  // External register model answering reads
  function automatic logic [7:0] dr_model(input logic p, input logic [1:0] r);
    return 8'h96 ^ {p, r, 5'b0};
  endfunction
  assign rd_data = rd_is_wcr ? (pot_sel ? 8'hC3 : 8'h5A) : dr_model(pot_sel, reg_sel);

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int n_wwcr, n_wdr, n_ld, n_st, n_step, n_up, n_oe, n_oe_bad, cs_hi;
  int l_pot, l_reg, l_data, l_all;

  always @(negedge clk) begin
    if (wr_wcr_stb) begin n_wwcr++; l_pot = pot_sel; l_reg = reg_sel; l_data = wr_data; end
    if (wr_dr_stb)  begin n_wdr++;  l_pot = pot_sel; l_reg = reg_sel; l_data = wr_data; end
    if (ld_wcr_stb) begin n_ld++;   l_pot = pot_sel; l_reg = reg_sel; l_all = all_pots; end
    if (st_dr_stb)  begin n_st++;   l_pot = pot_sel; l_reg = reg_sel; l_all = all_pots; end
    if (step_stb)   begin n_step++; l_pot = pot_sel; if (step_up) n_up++; end
    if (so_oe) n_oe++;
    if (cs_n) cs_hi++; else cs_hi = 0;
    if (cs_hi > 8 && so_oe) n_oe_bad++;
  end

  task automatic clear_mon();
    n_wwcr = 0; n_wdr = 0; n_ld = 0; n_st = 0; n_step = 0; n_up = 0; n_oe = 0;
    l_pot = -1; l_reg = -1; l_data = -1; l_all = -1;
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pause_here();
    hold_n = 1'b0;
    repeat (HALF) @(negedge clk);
    check_eq("R11 so_oe during pause", so_oe, 0);
    for (int k = 0; k < 3; k++) begin
      si = k[0];
      sck = 1'b1; repeat (HALF) @(negedge clk);
      sck = 1'b0; repeat (HALF) @(negedge clk);
    end
    check_eq("R11 so_oe after junk clocks", so_oe, 0);
    hold_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                           input int nbits, input int hold_at, input bit skip_fall,
                           output logic [7:0] rdb, output int oe_hits);
    logic [23:0] s;
    s = {b0, b1, b2};
    rdb = '0; oe_hits = 0;
    clear_mon();
    @(negedge clk);
    if (!skip_fall) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i == hold_at) pause_here();
      si = s[23-i];
      repeat (HALF) @(negedge clk);
      if (i >= 16 && i < 24) begin
        rdb[23-i] = so;
        if (so_oe) oe_hits++;
      end
      sck = 1'b1; repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check_eq("R1 so_oe at reset", so_oe, 0);
    check_eq("R13 no strobe at reset",
             int'({wr_wcr_stb, wr_dr_stb, ld_wcr_stb, st_dr_stb, step_stb}), 0);
  endtask

  task automatic t_unarmed();
    logic [7:0] r; int h;
    run_frame(8'h52, 8'hA1, 8'h77, 24, -1, 1'b1, r, h);
    check_eq("R12 write before first select", n_wwcr, 0);
  endtask

  task automatic t_writes();
    logic [7:0] r; int h;
    run_frame(8'h52, 8'hA1, 8'h3C, 24, -1, 1'b0, r, h);
    check_eq("R5 write wiper count", n_wwcr, 1);
    check_eq("R13 single-cycle strobe", n_wwcr + n_wdr + n_ld + n_st + n_step, 1);
    check_eq("R5 write wiper data", l_data, 8'h3C);
    check_eq("R5 write wiper pot", l_pot, 1);
    check_eq("R1 so idle after frame", n_oe_bad, 0);
    run_frame(8'h52, 8'hC8, 8'hA5, 24, -1, 1'b0, r, h);
    check_eq("R5 write dr count", n_wdr, 1);
    check_eq("R5 write dr data", l_data, 8'hA5);
    check_eq("R5 write dr reg", l_reg, 2);
    check_eq("R5 write dr pot", l_pot, 0);
  endtask

  task automatic t_reads();
    logic [7:0] r; int h;
    run_frame(8'h52, 8'h91, 8'h00, 24, -1, 1'b0, r, h);
    check_eq("R3 read wiper byte", r, 8'hC3);
    check_eq("R3 read wiper so_oe", h, 8);
    run_frame(8'h52, 8'hB4, 8'h00, 24, -1, 1'b0, r, h);
    check_eq("R3 read dr byte", r, dr_model(1'b0, 2'd1));
    check_eq("R13 read issues no strobe", n_wwcr + n_wdr + n_ld + n_st + n_step, 0);
    wip = 1'b1;
    run_frame(8'h52, 8'h50, 8'h00, 24, -1, 1'b0, r, h);
    check_eq("R4 status busy", r, 8'h01);
    wip = 1'b0;
    run_frame(8'h52, 8'h50, 8'h00, 24, -1, 1'b0, r, h);
    check_eq("R4 status idle", r, 8'h00);
  endtask

  task automatic t_transfers();
    logic [7:0] r; int h;
    run_frame(8'h52, 8'hD5, 8'h00, 16, -1, 1'b0, r, h);
    check_eq("R6 load count", n_ld, 1);
    check_eq("R6 load pointers", l_pot * 16 + l_reg * 2 + l_all, 16 + 2);
    run_frame(8'h52, 8'hE8, 8'h00, 16, -1, 1'b0, r, h);
    check_eq("R6 store count", n_st, 1);
    check_eq("R6 store pointers", l_pot * 16 + l_reg * 2 + l_all, 4);
    run_frame(8'h52, 8'h1C, 8'h00, 16, -1, 1'b0, r, h);
    check_eq("R7 global load", n_ld * 16 + l_reg * 2 + l_all, 16 + 6 + 1);
    run_frame(8'h52, 8'h84, 8'h00, 16, -1, 1'b0, r, h);
    check_eq("R7 global store", n_st * 16 + l_reg * 2 + l_all, 16 + 2 + 1);
  endtask

  task automatic t_steps();
    logic [7:0] r; int h;
    run_frame(8'h52, 8'h21, 8'b1101_0000, 21, -1, 1'b0, r, h);
    check_eq("R8 step count", n_step, 5);
    check_eq("R8 steps up", n_up, 3);
    check_eq("R8 step pot", l_pot, 1);
  endtask

  task automatic t_rejects();
    logic [7:0] r; int h;
    run_frame(8'h51, 8'hA1, 8'h11, 24, -1, 1'b0, r, h);
    check_eq("R2 wrong address", n_wwcr, 0);
    run_frame(8'h62, 8'hA1, 8'h11, 24, -1, 1'b0, r, h);
    check_eq("R2 wrong type", n_wwcr, 0);
    run_frame(8'h56, 8'h91, 8'h00, 24, -1, 1'b0, r, h);
    check_eq("R2 reserved bits in id, no SO", n_oe, 0);
    run_frame(8'h52, 8'hA1, 8'h11, 20, -1, 1'b0, r, h);
    check_eq("R9 short write", n_wwcr, 0);
    run_frame(8'h52, 8'hD5, 8'h00, 12, -1, 1'b0, r, h);
    check_eq("R9 short transfer", n_ld, 0);
    run_frame(8'h52, 8'h30, 8'h55, 24, -1, 1'b0, r, h);
    check_eq("R10 unknown opcode strobes", n_wwcr + n_wdr + n_ld + n_st + n_step, 0);
    check_eq("R10 unknown opcode SO", n_oe, 0);
    run_frame(8'h52, 8'hA3, 8'h55, 24, -1, 1'b0, r, h);
    check_eq("R10 reserved instruction bit", n_wwcr, 0);
  endtask

  task automatic t_pause();
    logic [7:0] r; int h;
    run_frame(8'h52, 8'hA1, 8'h6B, 24, 11, 1'b0, r, h);
    check_eq("R11 write across pause", n_wwcr * 256 + l_data, 256 + 8'h6B);
    run_frame(8'h52, 8'hBD, 8'h00, 24, 20, 1'b0, r, h);
    check_eq("R11 read across pause", r, dr_model(1'b1, 2'd3));
    check_eq("R11 SO enabled at samples", h, 8);
    run_frame(8'h52, 8'h21, 8'b1010_0000, 20, 18, 1'b0, r, h);
    check_eq("R11 steps across pause", n_step * 16 + n_up, 4 * 16 + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    n_oe_bad = 0; cs_hi = 0;
    clear_mon();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unarmed();
    t_writes();
    t_reads();
    t_transfers();
    t_steps();
    t_rejects();
    t_pause();
    check_eq("R1 SO never on while deselected", n_oe_bad, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule